// File: doc/BRIEF.md
# Dual Time Base with Utilization Counter

This block keeps two 64-bit time bases, a main one and an alternate one, that advance together by one on every cycle in which the shared tick enable is high. A third 64-bit counter, the utilization counter, also advances on the tick. It is meant to be loaded by software and to count onward from the value written. All three are reached through one 32-bit register port. A target code picks the counter, and two half selects pick its low word (bits 31:0) or its high word (bits 63:32). A half-word write changes only the chosen half and leaves the other half as it was.

A freeze pulse stops both time bases at their present values and a resume pulse lets them count on from there. The utilization counter is not frozen. A real-time-clock mode input changes how the main time base's low word behaves: it keeps only bits 29:7 of that word on both writes and reads. In this mode the low word looks like a clock that moves in steps of 128 ticks.

Top module: `tbase_dual`

## Requirements
- R1: A clock edge with `rst_n` low clears all three counters to zero and leaves the time bases in the running state (`running` = 1).
- R2: A write with `acc_lo` = 1 replaces bits 31:0 of the target counter with `wdata` and keeps bits 63:32. A write in the same cycle as a tick takes priority, so that counter does not increment in that cycle.
- R3: A write with `acc_hi` = 1 replaces bits 63:32 of the target counter with `wdata` and keeps bits 31:0.
- R4: `rdata` is combinational. With `acc_lo` = 1 it shows bits 31:0 of the target. Otherwise, with `acc_hi` = 1, it shows bits 63:32. The target codes are 0 for main, 1 for alternate and 2 for utilization. Code 3, or neither half selected, reads as 0.
- R5: While running, each cycle with `tick` = 1 adds one to both time bases at the next edge. A carry out of bit 31 reaches bit 32 in that same cycle.
- R6: The main and alternate time bases are independent: a write to one leaves the other's value unchanged.
- R7: A `stop_req` pulse freezes both time bases (`running` = 0 from the next edge). A stop while already frozen changes nothing.
- R8: A `start_req` pulse resumes counting from the frozen values. A start while already running changes nothing. When stop and start arrive in the same cycle, stop wins.
- R9: With `rtc_mode` = 1, writes to the main low word store `wdata & 32'h3FFFFF80` and reads of it return the stored bits ANDed with `32'h3FFFFF80`. The alternate and utilization counters are not affected.
- R10: The utilization counter loads written halves as in R2/R3 and increments on every tick, whether the time bases are running or frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable shared by all counters |
| stop_req | input | 1 | Freeze both time bases |
| start_req | input | 1 | Resume both time bases |
| rtc_mode | input | 1 | Mask the main low word with 0x3FFFFF80 |
| wr_en | input | 1 | Write strobe for the selected halves |
| acc_tgt | input | 2 | Target: 0 main, 1 alternate, 2 utilization, 3 none |
| acc_lo | input | 1 | Select bits 31:0 |
| acc_hi | input | 1 | Select bits 63:32 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected half |
| running | output | 1 | Time bases are counting |

## Verification
A wrong run state or a lost carry inside a counter appears at `rdata` as soon as the affected half is selected. The comparison is made on the cycle after the edge that caused it. If the word is not being read, the error stays in the counter until that half is selected. The bench therefore keeps a full model of all three counters and compares the selected half and `running` on every clock. Directed reads cover each half of each counter right after writes, freezes and carries. A wrong mask in real-time-clock mode shows up at the first read of the main low word, while the same read with the mode off reveals the stored bits.

// File: rtl/tbase_pkg.sv
// Package: shared sizes, target codes and the real-time-clock mask.
// Assumes the counter width is even so that it splits into two halves.
package tbase_pkg;
    parameter int TB_WIDTH = 64;
    localparam int TB_HALF = TB_WIDTH / 2;
    localparam int TB_NUM  = 3;

    typedef enum logic [1:0] {
        TGT_MAIN = 2'd0,
        TGT_ALT  = 2'd1,
        TGT_UTIL = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    localparam logic [TB_HALF-1:0] RTC_LOW_MASK = TB_HALF'(32'h3FFF_FF80);
endpackage

// File: rtl/tbase_counter.sv
// Module: one counter of WIDTH bits with half-word writes.
// Does: a write to either half replaces that half and suppresses the
// increment for the cycle; otherwise inc adds one with the low-half carry
// folded into the high half in the same cycle.
// Assumes: lo_mask is applied to low-half writes only; reset is
// synchronous and active low.
module tbase_counter #(
    parameter int WIDTH = 64,
    parameter int HALF  = WIDTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [HALF-1:0]  wdata,
    input  logic [HALF-1:0]  lo_mask,
    output logic [WIDTH-1:0] value
);
    logic [HALF-1:0] lo_q, hi_q;
    logic [HALF:0]   lo_sum;
    logic [HALF-1:0] hi_sum;

    // Increment path: low half plus one, carry into the high half.
    always_comb begin
        lo_sum = {1'b0, lo_q} + {{HALF{1'b0}}, 1'b1};
        hi_sum = hi_q + {{(HALF-1){1'b0}}, lo_sum[HALF]};
    end

    // Low half: write wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (wr_lo)
            lo_q <= wdata & lo_mask;
        else if (!wr_hi && inc)
            lo_q <= lo_sum[HALF-1:0];
    end

    // High half: write wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (wr_hi)
            hi_q <= wdata;
        else if (!wr_lo && inc)
            hi_q <= hi_sum;
    end

    assign value = {hi_q, lo_q};

    // R2
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo && !wr_hi |=> value[HALF-1:0] == $past(wdata & lo_mask)
                            && value[WIDTH-1:HALF] == $past(value[WIDTH-1:HALF]));
    // R3
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi && !wr_lo |=> value[WIDTH-1:HALF] == $past(wdata)
                            && value[HALF-1:0] == $past(value[HALF-1:0]));
    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !wr_lo && !wr_hi |=> value == $past(value) + 1'b1);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc && !wr_lo && !wr_hi |=> $stable(value));
endmodule

// File: rtl/tbase_run_ctrl.sv
// Module: run/freeze state shared by both time bases.
// Does: stop clears the run flag, start sets it; stop wins a tie.
// Assumes: requests are single-cycle pulses; reset enters running.
module tbase_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic start_req,
    output logic running
);
    // Run flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b1;
        else if (stop_req)
            running <= 1'b0;
        else if (start_req)
            running <= 1'b1;
    end

    // R7
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !running);
    // R8
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req && !stop_req |=> running);
    // R8
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_req && !stop_req |=> $stable(running));
endmodule

// File: rtl/tbase_dual.sv
// Module: main and alternate time bases plus utilization counter.
// Does: decodes the register port into per-counter half writes, gates the
// time-base increments with the run flag, and muxes one half onto rdata.
// Assumes: acc_tgt codes follow tbase_pkg::tgt_e; the real-time-clock mask
// applies only to the main low word.
module tbase_dual
    import tbase_pkg::*;
#(
    parameter int WIDTH = TB_WIDTH,
    parameter int HALF  = WIDTH / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            stop_req,
    input  logic            start_req,
    input  logic            rtc_mode,
    input  logic            wr_en,
    input  logic [1:0]      acc_tgt,
    input  logic            acc_lo,
    input  logic            acc_hi,
    input  logic [HALF-1:0] wdata,
    output logic [HALF-1:0] rdata,
    output logic            running
);
    localparam logic [HALF-1:0] MAIN_MASK = HALF'(RTC_LOW_MASK);

    logic [WIDTH-1:0] cnt_val [TB_NUM];
    logic [HALF-1:0]  mask_val [TB_NUM];
    logic [HALF-1:0]  rd_word;

    tbase_run_ctrl u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_req  (stop_req),
        .start_req (start_req),
        .running   (running)
    );

    for (genvar g = 0; g < TB_NUM; g++) begin : g_cnt
        logic sel_w, inc_w;
        assign sel_w = wr_en && (acc_tgt == 2'(g));
        if (g == int'(TGT_MAIN)) begin : g_mask
            assign mask_val[g] = rtc_mode ? MAIN_MASK : '1;
        end else begin : g_nomask
            assign mask_val[g] = '1;
        end
        if (g == int'(TGT_UTIL)) begin : g_inc_free
            assign inc_w = tick;
        end else begin : g_inc_gated
            assign inc_w = tick && running;
        end
        tbase_counter #(.WIDTH(WIDTH), .HALF(HALF)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc_w),
            .wr_lo   (sel_w && acc_lo),
            .wr_hi   (sel_w && acc_hi),
            .wdata   (wdata),
            .lo_mask (mask_val[g]),
            .value   (cnt_val[g])
        );
    end

    // Read mux: low half has priority, unused target reads zero.
    always_comb begin
        rd_word = '0;
        if (acc_tgt != TGT_NONE) begin
            if (acc_lo)
                rd_word = cnt_val[acc_tgt][HALF-1:0] & mask_val[acc_tgt];
            else if (acc_hi)
                rd_word = cnt_val[acc_tgt][WIDTH-1:HALF];
        end
    end

    assign rdata = rd_word;

    // R7
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !(wr_en && acc_tgt == TGT_MAIN && (acc_lo || acc_hi))
        |=> $stable(cnt_val[0]));
    // R10
    util_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running && tick && !(wr_en && acc_tgt == TGT_UTIL && (acc_lo || acc_hi))
        |=> cnt_val[2] == $past(cnt_val[2]) + 1'b1);
    // R4
    none_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_tgt == TGT_NONE |-> rdata == '0);
endmodule

// File: tb/tb_tbase_dual.sv
module tb_tbase_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, stop_req = 1'b0, start_req = 1'b0, rtc_mode = 1'b0;
    logic        wr_en = 1'b0, acc_lo = 1'b0, acc_hi = 1'b0;
    logic [1:0]  acc_tgt = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        running;

    int n_chk = 0;
    int n_fail = 0;
    bit model_live = 0;
    logic [63:0] m [3] = '{default: '0};
    bit m_run = 1;

    always #10 clk = ~clk;

    tbase_dual dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stop_req(stop_req),
        .start_req(start_req), .rtc_mode(rtc_mode), .wr_en(wr_en),
        .acc_tgt(acc_tgt), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .wdata(wdata), .rdata(rdata), .running(running)
    );

    function automatic logic [63:0] nxt(int i);
        logic [63:0] v = m[i];
        bit sel = wr_en && (acc_tgt == 2'(i));
        if (sel && (acc_lo || acc_hi)) begin
            if (acc_lo) v[31:0] = wdata & ((i == 0 && rtc_mode) ? 32'h3FFF_FF80 : 32'hFFFF_FFFF);
            if (acc_hi) v[63:32] = wdata;
        end else if (tick && (i == 2 || m_run)) begin
            v = v + 64'd1;
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_rd();
        if (acc_tgt == 2'd3) return 32'h0;
        if (acc_lo) return m[acc_tgt][31:0] & ((acc_tgt == 2'd0 && rtc_mode) ? 32'h3FFF_FF80 : 32'hFFFF_FFFF);
        if (acc_hi) return m[acc_tgt][63:32];
        return 32'h0;
    endfunction

    // Reference model update
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m[i] <= '0;
            m_run <= 1;
            model_live <= 1;
        end else begin
            for (int i = 0; i < 3; i++) m[i] <= nxt(i);
            if (stop_req) m_run <= 0;
            else if (start_req) m_run <= 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R4 read path, R1 run state)
    always @(posedge clk) begin
        #5;
        if (model_live) begin
            chk("R4 per-cycle rdata", rdata, exp_rd());
            chk("R1/R7 per-cycle running", {31'd0, running}, {31'd0, m_run});
        end
    end

    task automatic wr(input logic [1:0] t, input bit lo, input bit hi,
                      input logic [31:0] d, input bit tk);
        @(negedge clk);
        wr_en = 1; acc_tgt = t; acc_lo = lo; acc_hi = hi; wdata = d; tick = tk;
        @(negedge clk);
        wr_en = 0; tick = 0; acc_lo = 0; acc_hi = 0;
    endtask

    task automatic rd(input string tag, input logic [1:0] t, input bit lo,
                      input bit hi, input logic [31:0] exp);
        @(negedge clk);
        acc_tgt = t; acc_lo = lo; acc_hi = hi;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1;
        repeat (n) @(negedge clk);
        tick = 0;
    endtask

    task automatic pulse(input bit stp, input bit stt);
        @(negedge clk);
        stop_req = stp; start_req = stt;
        @(negedge clk);
        stop_req = 0; start_req = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        rd("R1 main lo after reset", 2'd0, 1, 0, 32'h0);
        rd("R1 alt hi after reset", 2'd1, 0, 1, 32'h0);
        rd("R1 util lo after reset", 2'd2, 1, 0, 32'h0);
        chk("R1 running after reset", {31'd0, running}, 32'd1);

        wr(2'd0, 1, 0, 32'hFFFF_FFFE, 0);
        wr(2'd0, 0, 1, 32'h0000_0001, 0);
        rd("R2 main lo written", 2'd0, 1, 0, 32'hFFFF_FFFE);
        rd("R3 main hi written, lo kept", 2'd0, 0, 1, 32'h0000_0001);

        ticks(3);
        rd("R5 carry into hi", 2'd0, 0, 1, 32'h0000_0002);
        rd("R5 lo after wrap", 2'd0, 1, 0, 32'h0000_0001);

        wr(2'd1, 0, 1, 32'hAAAA_5555, 0);
        rd("R3 alt hi written", 2'd1, 0, 1, 32'hAAAA_5555);
        rd("R3 alt lo kept", 2'd1, 1, 0, 32'h0000_0003);
        rd("R6 main hi untouched", 2'd0, 0, 1, 32'h0000_0002);
        wr(2'd1, 1, 0, 32'h1234_5678, 0);
        rd("R2 alt hi kept", 2'd1, 0, 1, 32'hAAAA_5555);
        rd("R6 main lo untouched", 2'd0, 1, 0, 32'h0000_0001);

        pulse(1, 0);
        chk("R7 running after stop", {31'd0, running}, 32'd0);
        ticks(5);
        rd("R7 main frozen", 2'd0, 1, 0, 32'h0000_0001);
        rd("R7 alt frozen", 2'd1, 1, 0, 32'h1234_5678);
        rd("R10 util counts while frozen", 2'd2, 1, 0, 32'h0000_0008);
        pulse(1, 0);
        chk("R7 stop while frozen", {31'd0, running}, 32'd0);
        rd("R7 main still frozen", 2'd0, 1, 0, 32'h0000_0001);

        pulse(0, 1);
        chk("R8 running after start", {31'd0, running}, 32'd1);
        pulse(0, 1);
        chk("R8 start while running", {31'd0, running}, 32'd1);
        ticks(2);
        rd("R8 main resumes from frozen", 2'd0, 1, 0, 32'h0000_0003);
        rd("R8 alt resumes", 2'd1, 1, 0, 32'h1234_567A);

        wr(2'd2, 0, 1, 32'h0000_0005, 0);
        wr(2'd2, 1, 0, 32'hFFFF_FFFF, 0);
        ticks(1);
        rd("R10 util hi after load+tick", 2'd2, 0, 1, 32'h0000_0006);
        rd("R10 util lo after load+tick", 2'd2, 1, 0, 32'h0000_0000);

        wr(2'd0, 1, 0, 32'h0000_0100, 1);
        rd("R2 write beats tick", 2'd0, 1, 0, 32'h0000_0100);

        pulse(1, 1);
        chk("R8 stop wins over start", {31'd0, running}, 32'd0);
        pulse(0, 1);

        rtc_mode = 1;
        wr(2'd0, 1, 0, 32'hFFFF_FFFF, 0);
        rd("R9 main lo masked", 2'd0, 1, 0, 32'h3FFF_FF80);
        wr(2'd1, 1, 0, 32'hFFFF_FFFF, 0);
        rd("R9 alt lo unmasked", 2'd1, 1, 0, 32'hFFFF_FFFF);
        ticks(1);
        rd("R9 masked read hides low bits", 2'd0, 1, 0, 32'h3FFF_FF80);
        rtc_mode = 0;
        rd("R9 stored value after mode off", 2'd0, 1, 0, 32'h3FFF_FF81);

        rd("R4 target 3 reads zero", 2'd3, 1, 0, 32'h0);
        rd("R4 no half selected reads zero", 2'd0, 0, 0, 32'h0);

        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            tick = 1'($urandom % 2);
            stop_req = ($urandom % 16) == 0;
            start_req = ($urandom % 12) == 0;
            rtc_mode = ($urandom % 8) == 0;
            wr_en = ($urandom % 5) == 0;
            acc_tgt = 2'($urandom % 4);
            acc_lo = 1'($urandom % 2);
            acc_hi = 1'($urandom % 2);
            wdata = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
        end
        @(negedge clk);
        wr_en = 0; tick = 0; stop_req = 0; start_req = 0;
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule